// File: doc/BRIEF.md
# Boundary-Scan Test Logic

This block is the complete test logic of a small boundary-scan device. A serial test port (clock, mode select, serial data in, an optional asynchronous reset) steers a sixteen-state controller. The controller sequences capture, shift and update operations on an instruction register and on one of three data registers. These are a one-bit bypass stage, a 32-bit identification register and a five-cell boundary register that sits between the device core and its pins. Serial data leaves on a falling-edge output that is valid only while shifting.

The decoded instruction does two things. It picks the data register that is placed in the serial path, and it picks what drives the pins. The pins can follow the core in normal operation, follow the boundary update stage, or be forced to high impedance. The core inputs can come from the pins or, for internal testing, from the boundary register. The core is modelled by plain pass-through ports: the output data and enable come from the core, and the input data goes to it.

Top module: `bscan_tap_top`

## Requirements
- R1: The controller follows the standard sixteen-state graph on each rising test-clock edge. It leaves Test-Logic-Reset for Run-Test/Idle when mode select is 0. An active-low asynchronous reset puts it in Test-Logic-Reset at any time.
- R2: Both pause states (Pause-DR, Pause-IR) are reachable, and so are the Exit2 states. Leaving a shift, pausing and resuming the shift keeps the bits already shifted and continues the same serial stream.
- R3: Holding mode select at 1 for five rising edges reaches Test-Logic-Reset from any state. Entering Test-Logic-Reset sets the active instruction to IDCODE.
- R4: Capture-IR loads 3'b001 into the instruction shift stage. Shift-IR moves serial input into bit 2 and presents bit 0 on serial output, so the first bit shifted in ends up as opcode bit 0.
- R5: The active instruction changes only on the edge that leaves Update-IR, or in Test-Logic-Reset. After reset it is IDCODE. Opcodes: EXTEST 000, SAMPLE 001, IDCODE 010, INTEST 011, CLAMP 100, HIGHZ 101, BYPASS 111, and 110 also acts as BYPASS.
- R6: BYPASS, 110, CLAMP and HIGHZ select a one-bit register that captures 0. Serial data emerges from it one shift later.
- R7: IDCODE selects a 32-bit register that captures 32'h0000B143 and shifts it out least significant bit first.
- R8: Under HIGHZ the pin enable is 0.
- R9: Under EXTEST and CLAMP the pins are driven from the boundary update stage. Cell 0 is the control, and a value of 0 there enables the drivers while 1 turns them off. Cells 1 and 2 give pin data bits 0 and 1.
- R10: The boundary register captures 0 into cell 0, core output bits 0 and 1 into cells 1 and 2, and pin input bits 0 and 1 into cells 3 and 4. Cell 0 is the first bit out. Its update stage loads only on Update-DR under EXTEST, SAMPLE or INTEST.
- R11: Under INTEST the core inputs take update cells 3 and 4, and the pin enable is 0.
- R12: Serial output changes on the falling test-clock edge, and its enable is 1 only during Shift-IR and Shift-DR.
- R13: Under IDCODE, SAMPLE, BYPASS and 110 the pins carry the core output data and enable, and the core inputs carry the pin inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising edges |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_oe | output | 1 | Serial output enable |
| core_out | input | 2 | Output data from the core |
| core_oe | input | 1 | Output enable from the core |
| core_in | output | 2 | Input data delivered to the core |
| pin_out | output | 2 | Data driven to the output pins |
| pin_oe | output | 1 | Output pin driver enable |
| pin_in | input | 2 | Values on the input pins |

## Verification
A wrong controller state shows on the next falling edge as a serial-output enable in the wrong cycle, or as a bit taken from the wrong register. Because the bench compares every port in every cycle, a misstep in the graph appears within one or two clocks. A corrupted instruction or update stage shows on the pin and core-input ports in the cycle after the edge that loaded it. A wrong capture value or shift direction shows in the serial stream as soon as the bad bit reaches the output end, at most 32 shifts later for the identification register.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_t;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b001;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b010;
    localparam logic [IR_W-1:0] OP_INTEST = 3'b011;
    localparam logic [IR_W-1:0] OP_CLAMP  = 3'b100;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b101;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_t;

    typedef struct packed {
        dr_sel_t sel;
        logic    pins_from_bsr;
        logic    pins_off;
        logic    core_from_bsr;
        logic    bsr_upd_en;
    } decode_t;

    function automatic decode_t decode_op(input logic [IR_W-1:0] op);
        decode_t d;
        d.sel           = DR_BYP;
        d.pins_from_bsr = 1'b0;
        d.pins_off      = 1'b0;
        d.core_from_bsr = 1'b0;
        d.bsr_upd_en    = 1'b0;
        case (op)
            OP_EXTEST: begin
                d.sel           = DR_BSR;
                d.pins_from_bsr = 1'b1;
                d.bsr_upd_en    = 1'b1;
            end
            OP_SAMPLE: begin
                d.sel        = DR_BSR;
                d.bsr_upd_en = 1'b1;
            end
            OP_INTEST: begin
                d.sel           = DR_BSR;
                d.pins_off      = 1'b1;
                d.core_from_bsr = 1'b1;
                d.bsr_upd_en    = 1'b1;
            end
            OP_IDCODE: d.sel = DR_ID;
            OP_CLAMP:  d.pins_from_bsr = 1'b1;
            OP_HIGHZ:  d.pins_off = 1'b1;
            default:   d.sel = DR_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bscan_tap_fsm.sv
module bscan_tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_o
);

    typedef struct packed {
        tap_state_t st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            TLR:     r_d.st = tms ? TLR    : RTI;
            RTI:     r_d.st = tms ? SEL_DR : RTI;
            SEL_DR:  r_d.st = tms ? SEL_IR : CAP_DR;
            CAP_DR:  r_d.st = tms ? EX1_DR : SH_DR;
            SH_DR:   r_d.st = tms ? EX1_DR : SH_DR;
            EX1_DR:  r_d.st = tms ? UPD_DR : PAU_DR;
            PAU_DR:  r_d.st = tms ? EX2_DR : PAU_DR;
            EX2_DR:  r_d.st = tms ? UPD_DR : SH_DR;
            UPD_DR:  r_d.st = tms ? SEL_DR : RTI;
            SEL_IR:  r_d.st = tms ? TLR    : CAP_IR;
            CAP_IR:  r_d.st = tms ? EX1_IR : SH_IR;
            SH_IR:   r_d.st = tms ? EX1_IR : SH_IR;
            EX1_IR:  r_d.st = tms ? UPD_IR : PAU_IR;
            PAU_IR:  r_d.st = tms ? EX2_IR : PAU_IR;
            EX2_IR:  r_d.st = tms ? UPD_IR : SH_IR;
            UPD_IR:  r_d.st = tms ? SEL_DR : RTI;
            default: r_d.st = TLR;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{st: TLR};
        else         r_q <= r_d;
    end

    assign state_o = r_q.st;

    // checker support: consecutive mode-select ones, saturating
    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          ones_q <= '0;
        else if (!tms)        ones_q <= '0;
        else if (ones_q != 7) ones_q <= ones_q + 3'd1;
    end

    a_r3_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd5) |-> (r_q.st == TLR));

    a_r1_leave_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == TLR && !tms) |=> (r_q.st == RTI));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
    import bscan_pkg::*;
#(
    parameter int              W       = IR_W,
    parameter logic [W-1:0]    CAP_PAT = 3'b001,
    parameter logic [W-1:0]    RST_OP  = OP_IDCODE
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_t   state,
    input  logic         tdi,
    output logic         so,
    output logic [W-1:0] op
);

    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] op;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (state)
            CAP_IR: r_d.sh = CAP_PAT;
            SH_IR:  r_d.sh = {tdi, r_q.sh[W-1:1]};
            UPD_IR: r_d.op = r_q.sh;
            TLR:    r_d.op = RST_OP;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '{sh: CAP_PAT, op: RST_OP};
        else         r_q <= r_d;
    end

    assign so = r_q.sh[0];
    assign op = r_q.op;

    a_r4_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_IR) |=> (r_q.sh == CAP_PAT));

    a_r5_op_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (state != UPD_IR && state != TLR) |=> $stable(r_q.op));

endmodule

// File: rtl/bscan_bsr.sv
module bscan_bsr
    import bscan_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int N_IN  = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  logic             tdi,
    input  decode_t          dec,
    input  logic [N_OUT-1:0] core_out,
    input  logic             core_oe,
    input  logic [N_IN-1:0]  pin_in,
    output logic             so,
    output logic [N_OUT-1:0] pin_out,
    output logic             pin_oe,
    output logic [N_IN-1:0]  core_in
);

    localparam int LEN    = 1 + N_OUT + N_IN;
    localparam int CTL    = 0;
    localparam int OUT_LO = 1;
    localparam int IN_LO  = 1 + N_OUT;

    typedef struct packed {
        logic [LEN-1:0] sr;
        logic [LEN-1:0] upd;
    } bsr_regs_t;

    bsr_regs_t r_d, r_q;
    logic      active;

    assign active = (dec.sel == DR_BSR);

    always_comb begin
        r_d = r_q;
        if (active) begin
            case (state)
                CAP_DR: r_d.sr = {pin_in, core_out, 1'b0};
                SH_DR:  r_d.sr = {tdi, r_q.sr[LEN-1:1]};
                UPD_DR: if (dec.bsr_upd_en) r_d.upd = r_q.sr;
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        pin_out = dec.pins_from_bsr ? r_q.upd[OUT_LO +: N_OUT] : core_out;
        if (dec.pins_off)           pin_oe = 1'b0;
        else if (dec.pins_from_bsr) pin_oe = ~r_q.upd[CTL];
        else                        pin_oe = core_oe;
        core_in = dec.core_from_bsr ? r_q.upd[IN_LO +: N_IN] : pin_in;
    end

    assign so = r_q.sr[0];

    a_r10_update_only_on_upd: assert property (@(posedge tck) disable iff (!trst_n)
        (state != UPD_DR) |=> $stable(r_q.upd));

endmodule

// File: rtl/bscan_tap_top.sv
module bscan_tap_top
    import bscan_pkg::*;
#(
    parameter int          N_OUT    = 2,
    parameter int          N_IN     = 2,
    parameter int          ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000B143
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [N_OUT-1:0] core_out,
    input  logic             core_oe,
    output logic [N_IN-1:0]  core_in,
    output logic [N_OUT-1:0] pin_out,
    output logic             pin_oe,
    input  logic [N_IN-1:0]  pin_in
);

    tap_state_t      state;
    logic [IR_W-1:0] op;
    logic            ir_so;
    logic            bsr_so;
    decode_t         dec;

    bscan_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    bscan_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .so     (ir_so),
        .op     (op)
    );

    assign dec = decode_op(op);

    bscan_bsr #(.N_OUT(N_OUT), .N_IN(N_IN)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .tdi      (tdi),
        .dec      (dec),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pin_in   (pin_in),
        .so       (bsr_so),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .core_in  (core_in)
    );

    // bypass and identification data registers
    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (dec.sel == DR_BYP) begin
            if (state == CAP_DR)     r_d.byp = 1'b0;
            else if (state == SH_DR) r_d.byp = tdi;
        end
        if (dec.sel == DR_ID) begin
            if (state == CAP_DR)     r_d.id = ID_VALUE;
            else if (state == SH_DR) r_d.id = {tdi, r_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    // serial output stage, falling edge
    typedef struct packed {
        logic tdo;
        logic oe;
    } out_regs_t;

    out_regs_t o_d, o_q;
    logic      dr_so;

    always_comb begin
        case (dec.sel)
            DR_ID:   dr_so = r_q.id[0];
            DR_BSR:  dr_so = bsr_so;
            default: dr_so = r_q.byp;
        endcase
        o_d.oe  = (state == SH_IR) || (state == SH_DR);
        o_d.tdo = (state == SH_IR) ? ir_so : dr_so;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo    = o_q.tdo;
    assign tdo_oe = o_q.oe;

    a_r8_highz_pins_off: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_HIGHZ) |-> !pin_oe);

    a_r7_id_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (state == CAP_DR && op == OP_IDCODE) |=> (r_q.id == ID_VALUE));

    a_r12_oe_only_shifting: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == SH_IR || state == SH_DR || state == EX1_IR || state == EX1_DR));

endmodule

// File: tb/bscan_tap_top_bench.sv
module bscan_tap_top_bench;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo, tdo_oe;
    logic [1:0] core_out = 2'b00;
    logic       core_oe = 1'b0;
    logic [1:0] core_in, pin_out, pin_in = 2'b00;
    logic       pin_oe;

    always #5 tck = ~tck;

    bscan_tap_top u_bscan_tap_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    // reference model state codes
    localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3,  M_SHD = 4,  M_E1D = 5,
                   M_PD  = 6,  M_E2D = 7,  M_UDR = 8,  M_SIR = 9,  M_CIR = 10, M_SHI = 11,
                   M_E1I = 12, M_PI  = 13, M_E2I = 14, M_UIR = 15;

    int         m_state;
    logic [2:0] m_instr;
    logic [4:0] m_upd;
    bit         irq[$];
    bit         drq[$];
    int         vectors = 0;
    int         fails = 0;
    string      cur_req = "R1";
    bit         done = 0;

    function automatic int nxt(int s, bit m);
        case (s)
            M_TLR: return m ? M_TLR : M_RTI;
            M_RTI: return m ? M_SDR : M_RTI;
            M_SDR: return m ? M_SIR : M_CDR;
            M_CDR, M_SHD: return m ? M_E1D : M_SHD;
            M_E1D: return m ? M_UDR : M_PD;
            M_PD:  return m ? M_E2D : M_PD;
            M_E2D: return m ? M_UDR : M_SHD;
            M_UDR, M_UIR: return m ? M_SDR : M_RTI;
            M_SIR: return m ? M_TLR : M_CIR;
            M_CIR, M_SHI: return m ? M_E1I : M_SHI;
            M_E1I: return m ? M_UIR : M_PI;
            M_PI:  return m ? M_E2I : M_PI;
            default: return m ? M_UIR : M_SHI;
        endcase
    endfunction

    function automatic bit is_bsr(logic [2:0] i);
        return (i == 3'b000) || (i == 3'b001) || (i == 3'b011);
    endfunction

    task automatic model_reset();
        m_state = M_TLR; m_instr = 3'b010; m_upd = '0;
        irq.delete(); drq.delete();
    endtask

    task automatic model_edge(bit m, bit d);
        case (m_state)
            M_CIR: begin irq.delete(); irq.push_back(1); irq.push_back(0); irq.push_back(0); end
            M_SHI: begin void'(irq.pop_front()); irq.push_back(d); end
            M_UIR: for (int i = 0; i < 3; i++) m_instr[i] = irq[i];
            M_TLR: m_instr = 3'b010;
            M_CDR: begin
                drq.delete();
                if (m_instr == 3'b010) begin
                    for (int i = 0; i < 32; i++) drq.push_back(32'h0000B143 >> i);
                end else if (is_bsr(m_instr)) begin
                    drq.push_back(0); drq.push_back(core_out[0]); drq.push_back(core_out[1]);
                    drq.push_back(pin_in[0]); drq.push_back(pin_in[1]);
                end else drq.push_back(0);
            end
            M_SHD: begin void'(drq.pop_front()); drq.push_back(d); end
            M_UDR: if (is_bsr(m_instr)) for (int i = 0; i < 5; i++) m_upd[i] = drq[i];
            default: ;
        endcase
        m_state = nxt(m_state, m);
    endtask

    task automatic chk(string name, logic [1:0] act, logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", cur_req, name, act, exp);
        end
    endtask

    task automatic compare();
        logic       e_oe, e_do;
        logic [1:0] e_po, e_ci;
        e_oe = (m_state == M_SHI) || (m_state == M_SHD);
        chk("tdo_oe (R12)", {1'b0, tdo_oe}, {1'b0, e_oe});
        if (e_oe) chk("tdo", {1'b0, tdo}, {1'b0, (m_state == M_SHI) ? irq[0] : drq[0]});
        case (m_instr)
            3'b000, 3'b100: begin e_po = m_upd[2:1]; e_do = ~m_upd[0]; end
            3'b101, 3'b011: begin e_po = core_out;   e_do = 1'b0;      end
            default:        begin e_po = core_out;   e_do = core_oe;   end
        endcase
        e_ci = (m_instr == 3'b011) ? m_upd[4:3] : pin_in;
        chk("pin_out", pin_out, e_po);
        chk("pin_oe", {1'b0, pin_oe}, {1'b0, e_do});
        chk("core_in", core_in, e_ci);
    endtask

    task automatic step(bit m, bit d);
        @(negedge tck); #1;
        compare();
        tms = m; tdi = d;
        @(posedge tck); #1;
        if (trst_n) model_edge(m, d);
    endtask

    task automatic scan_ir(logic [2:0] op, bit pause);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            step((i == 2) || (pause && i == 0), op[i]);
            if (pause && i == 0) begin step(0, 0); step(0, 0); step(1, 0); step(0, 0); end
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(logic [31:0] bits, int n, bit pause);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step((i == n - 1) || (pause && i == 1), bits[i]);
            if (pause && i == 1 && n > 2) begin step(0, 0); step(0, 0); step(1, 0); step(0, 0); end
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic pulse_trst();
        @(negedge tck); #1;
        trst_n = 0; model_reset();
        @(negedge tck); #1;
        compare();
        trst_n = 1;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge tck);
        @(negedge tck); #1; compare(); trst_n = 1;

        cur_req = "R7";  scan_dr(32'h0, 32, 0);
        cur_req = "R1";  step(1, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        cur_req = "R2";  scan_dr(32'hA5A5_1234, 32, 1);
        cur_req = "R5";  scan_ir(3'b101, 1);
        cur_req = "R8";  core_oe = 1; core_out = 2'b10; step(0, 0); step(0, 0);
        cur_req = "R6";  scan_ir(3'b111, 0); scan_dr(32'h0000_0005, 4, 0);
        cur_req = "R5";  scan_ir(3'b110, 0); scan_dr(32'h0000_0002, 3, 1);
        cur_req = "R13"; core_out = 2'b01; pin_in = 2'b10; step(0, 0); core_oe = 0; step(0, 0);
        cur_req = "R10"; scan_ir(3'b001, 0); core_out = 2'b11; pin_in = 2'b01;
        scan_dr(32'h0000_0014, 5, 0);
        cur_req = "R9";  scan_ir(3'b100, 0); core_out = 2'b00; step(0, 0);
        scan_ir(3'b000, 0); pin_in = 2'b11; scan_dr(32'h0000_000C, 5, 1);
        scan_dr(32'h0000_0003, 5, 0); pin_in = 2'b00; scan_dr(32'h0000_0002, 5, 0);
        cur_req = "R11"; scan_ir(3'b011, 0); scan_dr(32'h0000_0016, 5, 0);
        scan_dr(32'h0000_000E, 5, 0);
        cur_req = "R4";  scan_ir(3'b010, 0); scan_ir(3'b111, 1);
        cur_req = "R3";  step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0); scan_dr(32'h0, 32, 0);
        scan_ir(3'b111, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0); scan_dr(32'h0, 8, 0);
        cur_req = "R1";  scan_ir(3'b100, 0); step(1, 0); step(0, 0); step(0, 0);
        pulse_trst(); step(0, 0); scan_dr(32'h0, 32, 0);
        cur_req = "R12"; for (int i = 0; i < 4; i++) begin core_out = 2'(i); step(0, 0); end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule